// File: doc/BRIEF.md
# Sector Address Sequencer with End-of-Data Handling

This block keeps the working position inside a sectored sample memory and moves it one cell per sample strobe while a record, play or fast-forward operation is running. The position is a sector (row) number plus a cell (column) number inside that sector. The sector length comes in as a cells-per-sector value. A host issues operation requests. Some of these requests carry a sector number of their own, and the others resume from the sector the block already holds.

At every sector end the block makes one choice. It either loops back to cell 0 of the same sector, moves on to the next sector, hands over to a request that was queued, or halts. During play and search it watches an end-of-data bit read back from memory. When that bit is found, it halts the operation and raises an active-low interrupt. When a recording ends, it sends a one-cycle strobe so the memory can write the end-of-data marker at the position where recording stopped. During a search it raises a mute flag for the audio path.

Top module: `sector_seq`

## Requirements
- R1: After reset, `row_addr`=0, `col_addr`=0, `active`=0, `int_n`=1, `mute`=0 and `wr_eod`=0.
- R2: The op codes are 1 set-record, 2 record, 3 set-play, 4 play, 5 set-forward and 6 forward. Code 0 and code 7 are ignored. An accepted set-variant loads the row from `cmd_sector` and sets the column to 0. An accepted plain variant keeps the current row and sets the column to 0. The result is visible one cycle after the request. A set-variant whose `cmd_sector` is 640 or more is ignored.
- R3: While an operation runs, each `sample_stb` that is not at the sector's last column increments `col_addr` by one. Without a strobe, the address holds.
- R4: A set-variant that reaches column `sector_len`-1 on a strobe, with nothing queued, returns to column 0 of the same row.
- R5: A plain variant that reaches the last column of a sector below 639 moves to column 0 of the next row.
- R6: A record request that arrives during set-record, or a play request that arrives during set-play, is queued and does not disturb the running operation. At the sector end it takes over with no idle cycle. A queued set-variant moves to column 0 of its own sector. A queued plain variant moves to column 0 of the next row.
- R7: During play or search, a strobe that sees `eod_bit`=1 halts the operation with the address held and drives `int_n` low. Recording ignores `eod_bit`.
- R8: `stop_req` halts a running operation without an interrupt. If the operation was a recording, `wr_eod` pulses for one cycle while the address still shows the stop position. `stop_req` has no effect while idle.
- R9: A plain variant, or a queued plain variant, that reaches the last column of sector 639 halts with the address held and drives `int_n` low. `wr_eod` also pulses if the operation was a recording.
- R10: `mute` is 1 exactly while a set-forward or forward operation is running.
- R11: `int_n` stays low until the next request is accepted, and goes high in the same cycle that the new operation starts.
- R12: During play or search, a request that is not queued restarts the block at once. During recording, requests that are not queued are ignored. When `stop_req` and a request arrive together, the stop wins. When a request and a strobe arrive together, the request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Operation request strobe |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_sector | input | ADDR_W | Sector field of the request |
| stop_req | input | 1 | Halt the running operation |
| sample_stb | input | 1 | One pulse per cell step |
| sector_len | input | COL_W | Cells per sector |
| eod_bit | input | 1 | End-of-data bit at the current cell |
| row_addr | output | SEC_W | Current sector |
| col_addr | output | COL_W | Current cell in the sector |
| active | output | 1 | An operation is running |
| wr_eod | output | 1 | Write the end-of-data marker now |
| int_n | output | 1 | Active-low interrupt |
| mute | output | 1 | Mute the audio path |

## Verification
The stepping logic is run under every loop policy: set-play and set-forward wrapping inside one sector, plain play and forward crossing into the next sector, and handover from a queued set-variant and from a queued plain variant. Comparing these runs separates the loop, advance and handover decisions. End-of-data is applied during play and during recording, which checks that only the right modes react to it. Sector 639 is driven under both a plain play and a plain record, which exercises the exhaustion halt with and without the marker strobe. Simultaneous stop, request and strobe inputs pin down the priority order, and a rejected out-of-range sector number shows the address does not move.

// File: rtl/sector_seq_pkg.sv
package sector_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_SET_REC  = 3'd1,
    OP_REC      = 3'd2,
    OP_SET_PLAY = 3'd3,
    OP_PLAY     = 3'd4,
    OP_SET_FWD  = 3'd5,
    OP_FWD      = 3'd6
  } seq_op_e;

  function automatic logic op_known(input logic [2:0] op);
    return (op >= 3'd1) && (op <= 3'd6);
  endfunction

  function automatic logic op_is_set(input logic [2:0] op);
    return (op == OP_SET_REC) || (op == OP_SET_PLAY) || (op == OP_SET_FWD);
  endfunction

  function automatic logic op_is_rec(input logic [2:0] op);
    return (op == OP_SET_REC) || (op == OP_REC);
  endfunction

  function automatic logic op_is_play(input logic [2:0] op);
    return (op == OP_SET_PLAY) || (op == OP_PLAY);
  endfunction

  function automatic logic op_is_fwd(input logic [2:0] op);
    return (op == OP_SET_FWD) || (op == OP_FWD);
  endfunction

  // a request of the same kind as a running set-record/set-play waits for the sector end
  function automatic logic op_queues(input logic [2:0] mode, input logic [2:0] op);
    return ((mode == OP_SET_REC) && op_is_rec(op)) ||
           ((mode == OP_SET_PLAY) && op_is_play(op));
  endfunction

endpackage

// File: rtl/seq_addr.sv
module seq_addr #(
  parameter int SEC_N = 640,
  parameter int SEC_W = 10,
  parameter int COL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEC_W-1:0] load_row,
  input  logic             col_step,
  input  logic             col_wrap,
  input  logic             row_step,
  input  logic [COL_W-1:0] sector_len,
  output logic [SEC_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             at_end,
  output logic             at_last
);

  localparam logic [SEC_W-1:0] LAST_ROW = SEC_W'(SEC_N - 1);

  function automatic logic [COL_W-1:0] last_col(input logic [COL_W-1:0] len);
    return len - COL_W'(1);
  endfunction

  assign at_end  = (col == last_col(sector_len));
  assign at_last = (row == LAST_ROW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (load) begin
      row <= load_row;
      col <= '0;
    end else if (row_step) begin
      row <= row + SEC_W'(1);
      col <= '0;
    end else if (col_wrap) begin
      col <= '0;
    end else if (col_step) begin
      col <= col + COL_W'(1);
    end
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import sector_seq_pkg::*;
#(
  parameter int SEC_N  = 640,
  parameter int SEC_W  = 10,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_sector,
  input  logic              stop_req,
  input  logic              sample_stb,
  input  logic              eod_bit,
  input  logic              at_end,
  input  logic              at_last,
  input  logic [SEC_W-1:0]  cur_row,
  output logic              load,
  output logic [SEC_W-1:0]  load_row,
  output logic              col_step,
  output logic              col_wrap,
  output logic              row_step,
  output logic              active,
  output logic              int_n,
  output logic              mute,
  output logic              wr_eod,
  output logic              start_ev,
  output logic              queue_ev,
  output logic              eod_ev,
  output logic              handoff_ev,
  output logic              exhaust_ev,
  output logic              halt_ev
);

  seq_op_e          mode;
  seq_op_e          pend_op;
  logic             pend_vld;
  logic [SEC_W-1:0] pend_row;

  logic cmd_ok, running, step, end_ev, plain_next, stop_ev;

  assign running  = (mode != OP_NONE);
  assign cmd_ok   = cmd_valid && op_known(cmd_op) &&
                    (!op_is_set(cmd_op) || (cmd_sector < ADDR_W'(SEC_N)));
  assign queue_ev = cmd_ok && !stop_req && running && op_queues(mode, cmd_op);
  assign start_ev = cmd_ok && !stop_req && !queue_ev && !(running && op_is_rec(mode));
  assign stop_ev  = stop_req && running;

  assign step       = running && sample_stb && !stop_req && !start_ev;
  assign eod_ev     = step && !op_is_rec(mode) && eod_bit;
  assign end_ev     = step && !eod_ev && at_end;
  assign handoff_ev = end_ev && pend_vld;
  assign plain_next = handoff_ev ? !op_is_set(pend_op) : !op_is_set(mode);
  assign exhaust_ev = end_ev && plain_next && at_last;
  assign halt_ev    = stop_ev || eod_ev || exhaust_ev;

  assign col_step = step && !eod_ev && !at_end;
  assign col_wrap = end_ev && !handoff_ev && op_is_set(mode);
  assign row_step = end_ev && plain_next && !at_last;
  assign load     = start_ev || (handoff_ev && op_is_set(pend_op));
  assign load_row = start_ev ? (op_is_set(cmd_op) ? cmd_sector[SEC_W-1:0] : cur_row)
                             : pend_row;

  assign active = running;
  assign mute   = op_is_fwd(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= OP_NONE;
      pend_vld <= 1'b0;
      pend_op  <= OP_NONE;
      pend_row <= '0;
      int_n    <= 1'b1;
      wr_eod   <= 1'b0;
    end else begin
      wr_eod <= op_is_rec(mode) && (stop_ev || exhaust_ev);
      if (halt_ev)         mode <= OP_NONE;
      else if (start_ev)   mode <= seq_op_e'(cmd_op);
      else if (handoff_ev) mode <= pend_op;

      if (queue_ev) begin
        pend_vld <= 1'b1;
        pend_op  <= seq_op_e'(cmd_op);
        pend_row <= cmd_sector[SEC_W-1:0];
      end else if (handoff_ev || halt_ev || start_ev) begin
        pend_vld <= 1'b0;
      end

      if (start_ev)                  int_n <= 1'b1;
      else if (eod_ev || exhaust_ev) int_n <= 1'b0;
    end
  end

endmodule

// File: rtl/sector_seq.sv
module sector_seq #(
  parameter int SEC_N  = 640,
  parameter int ADDR_W = 15,
  parameter int COL_W  = 12,
  localparam int SEC_W = $clog2(SEC_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_sector,
  input  logic              stop_req,
  input  logic              sample_stb,
  input  logic [COL_W-1:0]  sector_len,
  input  logic              eod_bit,
  output logic [SEC_W-1:0]  row_addr,
  output logic [COL_W-1:0]  col_addr,
  output logic              active,
  output logic              wr_eod,
  output logic              int_n,
  output logic              mute
);

  logic             load, col_step, col_wrap, row_step, at_end, at_last;
  logic [SEC_W-1:0] load_row;
  logic             start_ev, queue_ev, eod_ev, handoff_ev, exhaust_ev, halt_ev;

  seq_ctrl #(.SEC_N(SEC_N), .SEC_W(SEC_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_sector, .stop_req, .sample_stb,
    .eod_bit, .at_end, .at_last, .cur_row(row_addr),
    .load, .load_row, .col_step, .col_wrap, .row_step,
    .active, .int_n, .mute, .wr_eod,
    .start_ev, .queue_ev, .eod_ev, .handoff_ev, .exhaust_ev, .halt_ev
  );

  seq_addr #(.SEC_N(SEC_N), .SEC_W(SEC_W), .COL_W(COL_W)) u_addr (
    .clk, .rst_n, .load, .load_row, .col_step, .col_wrap, .row_step,
    .sector_len, .row(row_addr), .col(col_addr), .at_end, .at_last
  );

endmodule

// File: rtl/sector_seq_chk.sv
module sector_seq_chk #(
  parameter int SEC_N = 640,
  parameter int COL_W = 12,
  parameter int SEC_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             stop_req,
  input logic             sample_stb,
  input logic             eod_bit,
  input logic [COL_W-1:0] sector_len,
  input logic [SEC_W-1:0] row_addr,
  input logic [COL_W-1:0] col_addr,
  input logic             active,
  input logic             wr_eod,
  input logic             int_n,
  input logic             mute,
  input logic             eod_ev,
  input logic             exhaust_ev
);

  a_r2_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    row_addr < SEC_W'(SEC_N));

  a_r3_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> col_addr < sector_len);

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sample_stb && !stop_req && !cmd_valid && !eod_bit &&
     col_addr != sector_len - COL_W'(1))
    |=> col_addr == COL_W'($past(col_addr) + COL_W'(1)));

  a_r3_hold_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sample_stb && !cmd_valid && !stop_req)
    |=> ($stable(col_addr) && $stable(row_addr)));

  a_r7_eod_halts: assert property (@(posedge clk) disable iff (!rst_n)
    eod_ev |=> (!active && !int_n));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eod |=> !wr_eod);

  a_r8_marker_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eod |-> !active);

  a_r9_exhaust_irq: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust_ev |=> (!active && !int_n));

  a_r10_mute_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    mute |-> active);

  a_r11_irq_with_halt: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $fell(active));

endmodule

bind sector_seq sector_seq_chk #(.SEC_N(SEC_N), .COL_W(COL_W), .SEC_W(SEC_W)) u_chk (.*);

// File: tb/sim_sector_seq.sv
module sim_sector_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 12;
  localparam int ADDR_W = 15;
  localparam logic [2:0] SR = 3'd1, RC = 3'd2, SP = 3'd3, PL = 3'd4, SF = 3'd5, FW = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, stop_req = 0, sample_stb = 0, eod_bit = 0;
  logic [2:0] cmd_op = '0;
  logic [ADDR_W-1:0] cmd_sector = '0;
  logic [COL_W-1:0] sector_len = 12'd4;
  logic [9:0] row_addr;
  logic [COL_W-1:0] col_addr;
  logic active, wr_eod, int_n, mute;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_seq u0 (.clk, .rst_n, .cmd_valid, .cmd_op, .cmd_sector, .stop_req,
                 .sample_stb, .sector_len, .eod_bit, .row_addr, .col_addr,
                 .active, .wr_eod, .int_n, .mute);

  typedef struct {
    int due; int r; int c; logic a; logic i; logic m; logic w; string tag;
  } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, failures = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the expectation due in this cycle and compares
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (row_addr != 10'(e.r) || col_addr != COL_W'(e.c) || active != e.a ||
          int_n != e.i || mute != e.m || wr_eod != e.w) begin
        failures++;
        $display("FAIL %s: got row=%0d col=%0d act=%0b int_n=%0b mute=%0b wr_eod=%0b exp row=%0d col=%0d act=%0b int_n=%0b mute=%0b wr_eod=%0b",
                 e.tag, row_addr, col_addr, active, int_n, mute, wr_eod,
                 e.r, e.c, e.a, e.i, e.m, e.w);
      end
    end
  end

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic t(input logic stb, cv, input logic [2:0] op, input int sec,
                   input logic stp, eod, input int er, ec,
                   input logic ea, ei, em, ew, input string tag);
    exp_t e;
    sample_stb = stb; cmd_valid = cv; cmd_op = op; cmd_sector = ADDR_W'(sec);
    stop_req = stp; eod_bit = eod;
    e.due = cyc + 1; e.r = er; e.c = ec; e.a = ea; e.i = ei; e.m = em; e.w = ew; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    sample_stb = 0; cmd_valid = 0; cmd_op = '0; stop_req = 0; eod_bit = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t(0,0,0,0,0,0, 0,0,0,1,0,0, "R1 reset state");
    t(0,1,SP,5,0,0, 5,0,1,1,0,0, "R2 set-play load");
    t(0,0,0,0,0,0, 5,0,1,1,0,0, "R3 hold no strobe");
    t(1,0,0,0,0,0, 5,1,1,1,0,0, "R3 step");
    t(1,0,0,0,0,0, 5,2,1,1,0,0, "R3 step");
    t(1,0,0,0,0,0, 5,3,1,1,0,0, "R3 step");
    t(1,0,0,0,0,0, 5,0,1,1,0,0, "R4 set-play wrap");
    t(0,1,PL,0,0,0, 5,0,1,1,0,0, "R6 queued play no disturb");
    t(1,0,0,0,0,0, 5,1,1,1,0,0, "R6 step");
    t(1,0,0,0,0,0, 5,2,1,1,0,0, "R6 step");
    t(1,0,0,0,0,0, 5,3,1,1,0,0, "R6 step");
    t(1,0,0,0,0,0, 6,0,1,1,0,0, "R6 plain handoff next row");
    t(1,0,0,0,0,0, 6,1,1,1,0,0, "R3 step after handoff");
    t(1,0,0,0,0,1, 6,1,0,0,0,0, "R7 play eod halt");
    t(1,0,0,0,0,0, 6,1,0,0,0,0, "R11 irq held idle");
    t(0,1,RC,0,0,0, 6,0,1,1,0,0, "R11 R2 plain record clears irq");
    t(1,0,0,0,0,1, 6,1,1,1,0,0, "R7 record ignores eod");
    t(0,0,0,0,1,0, 6,1,0,1,0,1, "R8 stop record marker");
    t(0,0,0,0,0,0, 6,1,0,1,0,0, "R8 marker one cycle");
    t(0,1,SF,7,0,0, 7,0,1,1,1,0, "R10 set-forward mute");
    t(1,0,0,0,0,0, 7,1,1,1,1,0, "R3 fwd step");
    t(1,0,0,0,0,0, 7,2,1,1,1,0, "R3 fwd step");
    t(1,0,0,0,0,0, 7,3,1,1,1,0, "R3 fwd step");
    t(1,0,0,0,0,0, 7,0,1,1,1,0, "R4 set-forward wrap");
    t(0,1,FW,0,0,0, 7,0,1,1,1,0, "R12 forward restarts");
    t(1,0,0,0,0,0, 7,1,1,1,1,0, "R3 step");
    t(1,0,0,0,0,0, 7,2,1,1,1,0, "R3 step");
    t(1,0,0,0,0,0, 7,3,1,1,1,0, "R3 step");
    t(1,0,0,0,0,0, 8,0,1,1,1,0, "R5 forward next row");
    t(1,0,0,0,0,1, 8,0,0,0,0,0, "R7 R10 forward eod halt unmute");
    t(0,1,SR,639,0,0, 639,0,1,1,0,0, "R2 set-record 639");
    t(0,1,SR,2,0,0, 639,0,1,1,0,0, "R6 queued set-record");
    t(1,0,0,0,0,0, 639,1,1,1,0,0, "R3 step");
    t(1,0,0,0,0,0, 639,2,1,1,0,0, "R3 step");
    t(1,0,0,0,0,0, 639,3,1,1,0,0, "R3 step");
    t(1,0,0,0,0,0, 2,0,1,1,0,0, "R6 set handoff own sector");
    t(0,1,PL,0,0,0, 2,0,1,1,0,0, "R12 play ignored in record");
    t(1,0,0,0,0,1, 2,1,1,1,0,0, "R12 still recording");
    t(0,0,0,0,1,0, 2,1,0,1,0,1, "R8 stop set-record marker");
    t(0,1,SP,639,0,0, 639,0,1,1,0,0, "R2 set-play 639");
    t(0,1,PL,0,0,0, 639,0,1,1,0,0, "R6 queue plain at last");
    t(1,0,0,0,0,0, 639,1,1,1,0,0, "R3 step");
    t(1,0,0,0,0,0, 639,2,1,1,0,0, "R3 step");
    t(1,0,0,0,0,0, 639,3,1,1,0,0, "R3 step");
    t(1,0,0,0,0,0, 639,3,0,0,0,0, "R9 play exhausted");
    t(0,1,RC,0,0,0, 639,0,1,1,0,0, "R2 plain record at 639");
    t(1,0,0,0,0,0, 639,1,1,1,0,0, "R3 step");
    t(1,0,0,0,0,0, 639,2,1,1,0,0, "R3 step");
    t(1,0,0,0,0,0, 639,3,1,1,0,0, "R3 step");
    t(1,0,0,0,0,0, 639,3,0,0,0,1, "R9 record exhausted marker");
    t(0,1,SR,640,0,0, 639,3,0,0,0,0, "R2 sector 640 rejected");
    t(0,0,0,0,1,0, 639,3,0,0,0,0, "R8 stop while idle");
    t(0,1,3'd7,3,0,0, 639,3,0,0,0,0, "R2 code 7 ignored");
    t(0,1,SP,3,0,0, 3,0,1,1,0,0, "R2 set-play 3");
    t(0,1,FW,0,1,0, 3,0,0,1,0,0, "R12 stop beats request");
    t(1,1,SP,4,0,0, 4,0,1,1,0,0, "R12 request beats strobe");
    @(negedge clk);
    @(negedge clk);
    if (q.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard: got %0d pending exp 0", q.size());
    end
    finish_run();
  end
endmodule